// File: doc/BRIEF.md
# Test-Clock Frequency Meter with Pass Window

This block measures the frequency of one of several test clocks against a reference clock. The reference frequency is supplied as a kHz value. A start pulse that carries a nonzero source index begins a measurement. The block first holds a clear phase and a programmable settling delay, counted in reference cycles, so that the input selection can settle. It then opens a counting gate that lasts 2^N microsecond ticks. Test-clock edges are counted in the test-clock domain. The count crosses into the reference domain in Gray code. From the count the block works out a result in kHz and raises a completion flag.

Each result is also graded against a programmable kHz window. Exactly one of three flags is set: in-window, above the maximum, or below the minimum. A start pulse with source index 0 returns the block to rest. A start pulse during a measurement abandons it and begins again from the clear phase.

The controller has five states: IDLE, CLEAR, SETTLE, GATE and DRAIN. The transitions are:
- IDLE→CLEAR on start with a nonzero index.
- CLEAR→SETTLE after the fixed clear length.
- SETTLE→GATE once the settle count is reached.
- GATE→DRAIN on the last gate tick.
- DRAIN→IDLE after the fixed drain length, which latches the result.
- Any state→CLEAR on start with a nonzero index.
- Any state→IDLE on start with index 0.

Top module: `freq_meter`

## Requirements
- R1: After reset, `running`, `done`, `pass`, `fast` and `slow` are 0 and `result_khz` is 0.
- R2: A start pulse with nonzero `src_sel` makes `running` 1 and clears `done`, `pass`, `fast` and `slow` at the following clock edge.
- R3: A start pulse with `src_sel` = 0 makes `running` and `done` 0 at the following edge. No measurement completes afterwards until another start pulse arrives.
- R4: Each unit added to `settle_cycles` adds exactly one reference cycle to the time from the start pulse to `done`.
- R5: The gate lasts D·2^N reference cycles, where N = `gate_log2` and D = max(1, floor(`ref_khz`/1000)). Raising N by one therefore adds D·2^N cycles to the time from the start pulse to `done`.
- R6: `result_khz` equals (gated edge count × 1000) >> N. It lies within 2·((1000>>N)+1) of the true test frequency expressed against the stated `ref_khz`, and saturates at all ones.
- R7: While `done` is 1, exactly one of `fast` (result > `max_khz`), `slow` (result < `min_khz`, and not fast) and `pass` (neither) is 1. All three are 0 while `done` is 0.
- R8: With `min_khz` = 0 and `max_khz` = 0x1FFFFFF, `pass` is always 1 on completion.
- R9: A start pulse during a measurement abandons it. The new run takes the same start-to-`done` time as a fresh run with the same settings, and its result is correct.
- R10: `result_khz` and `done` hold steady from completion until the next start pulse.
- R11: Source index k (1..NUM_SRC) measures `test_clks[k-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: writes `src_sel` and begins a run, or stops when the index is 0 |
| src_sel | input | SRC_W | Source index; 0 means idle |
| test_clks | input | NUM_SRC | Clocks under test |
| ref_khz | input | KHZ_W | Reference frequency in kHz |
| settle_cycles | input | DLY_W | Settling delay in reference cycles |
| gate_log2 | input | IVL_W | Gate length exponent N (2^N microsecond ticks) |
| min_khz | input | KHZ_W | Lower limit of the pass window |
| max_khz | input | KHZ_W | Upper limit of the pass window |
| result_khz | output | KHZ_W | Measured frequency in kHz, valid while `done` |
| running | output | 1 | Measurement in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | Result inside the window |
| fast | output | 1 | Result above `max_khz` |
| slow | output | 1 | Result below `min_khz` |

## Verification
The bench uses the default parameters: three test clocks, a clear length of 8 cycles and a drain length of 24 cycles. It drives `ref_khz` as small multiples of 1000, so one microsecond tick spans only one to three reference cycles. Gate exponents up to 6 then complete in a few hundred cycles. This lets the latency differences for the settle delay and the gate length be compared exactly, and lets many random source, window and exponent combinations run in one short simulation.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETTLE,
        ST_GATE,
        ST_DRAIN
    } fm_state_e;
endpackage

// File: rtl/fm_us_tick.sv
module fm_us_tick #(
    parameter int KHZ_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [KHZ_W-1:0] ref_khz,
    output logic             tick
);
    logic [KHZ_W-1:0] div_raw;
    logic [KHZ_W-1:0] div_len;
    logic [KHZ_W-1:0] cnt_q;

    always_comb begin
        div_raw = ref_khz / KHZ_W'(1000);
        div_len = (div_raw == '0) ? KHZ_W'(1) : div_raw;
        tick    = !restart && (cnt_q == div_len - KHZ_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + KHZ_W'(1);
        end
    end
endmodule

// File: rtl/fm_edge_count.sv
module fm_edge_count #(
    parameter int CNT_W = 24
) (
    input  logic             test_clk,
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    output logic [CNT_W-1:0] count_ref
);
    logic             run_m, run_s, clr_m, clr_s;
    logic [CNT_W-1:0] bin_q, bin_d, gray_q;
    logic [CNT_W-1:0] gray_m, gray_s;

    always_comb begin
        if (clr_s) begin
            bin_d = '0;
        end else if (run_s) begin
            bin_d = bin_q + CNT_W'(1);
        end else begin
            bin_d = bin_q;
        end
    end

    // test-clock domain: synchronise controls, count edges, publish Gray code
    always_ff @(posedge test_clk or negedge rst_n) begin
        if (!rst_n) begin
            run_m  <= 1'b0;
            run_s  <= 1'b0;
            clr_m  <= 1'b0;
            clr_s  <= 1'b0;
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            run_m  <= run;
            run_s  <= run_m;
            clr_m  <= clr;
            clr_s  <= clr_m;
            bin_q  <= bin_d;
            gray_q <= bin_d ^ (bin_d >> 1);
        end
    end

    // reference domain: two-flop capture of the Gray count
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            gray_m <= '0;
            gray_s <= '0;
        end else begin
            gray_m <= gray_q;
            gray_s <= gray_m;
        end
    end

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            count_ref[i] = ^(gray_s >> i);
        end
    end
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
    parameter int NUM_SRC   = 3,
    parameter int KHZ_W     = 25,
    parameter int DLY_W     = 8,
    parameter int IVL_W     = 4,
    parameter int CNT_W     = 24,
    parameter int CLEAR_CYC = 8,
    parameter int DRAIN_CYC = 24,
    localparam int SRC_W    = $clog2(NUM_SRC + 1)
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [NUM_SRC-1:0] test_clks,
    input  logic [KHZ_W-1:0]   ref_khz,
    input  logic [DLY_W-1:0]   settle_cycles,
    input  logic [IVL_W-1:0]   gate_log2,
    input  logic [KHZ_W-1:0]   min_khz,
    input  logic [KHZ_W-1:0]   max_khz,
    output logic [KHZ_W-1:0]   result_khz,
    output logic               running,
    output logic               done,
    output logic               pass,
    output logic               fast,
    output logic               slow
);
    import fm_pkg::*;

    localparam int DR_W   = $clog2(DRAIN_CYC + CLEAR_CYC + 1);
    localparam int PH_W   = ((DLY_W > DR_W) ? DLY_W : DR_W) + 1;
    localparam int TICK_W = (1 << IVL_W) + 1;
    localparam int PROD_W = CNT_W + 10;

    fm_state_e        state_q, state_d;
    logic [PH_W-1:0]  ph_cnt;
    logic [TICK_W-1:0] tick_cnt, gate_last;
    logic [SRC_W-1:0] src_q;
    logic             test_clk, tick, gate_end, finish;
    logic [CNT_W-1:0] count_ref;
    logic [PROD_W-1:0] prod, scaled;
    logic [KHZ_W-1:0] res_sat;
    logic             res_fast, res_slow;

    // source selection
    always_comb begin
        test_clk = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_q == SRC_W'(i + 1)) begin
                test_clk = test_clks[i];
            end
        end
    end

    fm_us_tick #(.KHZ_W(KHZ_W)) tick_i (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .restart (state_q != ST_GATE),
        .ref_khz (ref_khz),
        .tick    (tick)
    );

    fm_edge_count #(.CNT_W(CNT_W)) cnt_i (
        .test_clk  (test_clk),
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .run       (state_q == ST_GATE),
        .clr       ((state_q == ST_CLEAR) || (state_q == ST_SETTLE)),
        .count_ref (count_ref)
    );

    always_comb begin
        gate_last = (TICK_W'(1) << gate_log2) - TICK_W'(1);
        gate_end  = (state_q == ST_GATE) && tick && (tick_cnt == gate_last);
        finish    = (state_q == ST_DRAIN) && (ph_cnt == PH_W'(DRAIN_CYC - 1));
        prod      = PROD_W'(count_ref) * PROD_W'(1000);
        scaled    = prod >> gate_log2;
        res_sat   = (scaled > PROD_W'({KHZ_W{1'b1}})) ? {KHZ_W{1'b1}} : scaled[KHZ_W-1:0];
        res_fast  = res_sat > max_khz;
        res_slow  = !res_fast && (res_sat < min_khz);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_CLEAR:  if (ph_cnt == PH_W'(CLEAR_CYC - 1)) state_d = ST_SETTLE;
            ST_SETTLE: if (ph_cnt == PH_W'(settle_cycles)) state_d = ST_GATE;
            ST_GATE:   if (gate_end) state_d = ST_DRAIN;
            ST_DRAIN:  if (finish) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (start) begin
            state_d = (src_sel != '0) ? ST_CLEAR : ST_IDLE;
        end
    end

    // state register and phase counters
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ph_cnt   <= '0;
            tick_cnt <= '0;
            src_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start || (state_d != state_q)) begin
                ph_cnt <= '0;
            end else begin
                ph_cnt <= ph_cnt + PH_W'(1);
            end
            if (state_q != ST_GATE) begin
                tick_cnt <= '0;
            end else if (tick) begin
                tick_cnt <= tick_cnt + TICK_W'(1);
            end
            if (start) begin
                src_q <= src_sel;
            end
        end
    end

    // status and result outputs
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            result_khz <= '0;
            running    <= 1'b0;
            done       <= 1'b0;
            pass       <= 1'b0;
            fast       <= 1'b0;
            slow       <= 1'b0;
        end else if (start) begin
            running <= (src_sel != '0);
            done    <= 1'b0;
            pass    <= 1'b0;
            fast    <= 1'b0;
            slow    <= 1'b0;
        end else if (finish) begin
            running    <= 1'b0;
            done       <= 1'b1;
            result_khz <= res_sat;
            fast       <= res_fast;
            slow       <= res_slow;
            pass       <= !res_fast && !res_slow;
        end
    end
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
    parameter int KHZ_W = 25,
    parameter int SRC_W = 2
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic             start,
    input logic [SRC_W-1:0] src_sel,
    input logic [KHZ_W-1:0] result_khz,
    input logic             running,
    input logic             done,
    input logic             pass,
    input logic             fast,
    input logic             slow
);
    // R2
    start_clears_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (start && src_sel != '0) |=> (running && !done && !pass && !fast && !slow));

    // R3
    stop_idle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (start && src_sel == '0) |=> (!running && !done));

    // R7
    grade_onehot_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        done |-> ($countones({pass, fast, slow}) == 1));

    // R7
    grade_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !done |-> !(pass || fast || slow));

    // R10
    result_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result_khz)));

    // R2
    run_done_excl_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(running && done));
endmodule

bind freq_meter fm_checker #(.KHZ_W(KHZ_W), .SRC_W(SRC_W)) chk_i (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .start      (start),
    .src_sel    (src_sel),
    .result_khz (result_khz),
    .running    (running),
    .done       (done),
    .pass       (pass),
    .fast       (fast),
    .slow       (slow)
);

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
    localparam int NUM_SRC = 3;
    localparam int KHZ_W   = 25;
    localparam int SRC_W   = 2;

    logic               clk_ref = 1'b0;
    logic               rst_n   = 1'b0;
    logic               start   = 1'b0;
    logic [SRC_W-1:0]   src_sel = '0;
    logic [NUM_SRC-1:0] test_clks = '0;
    logic [KHZ_W-1:0]   ref_khz = 25'd2000;
    logic [7:0]         settle_cycles = '0;
    logic [3:0]         gate_log2 = 4'd4;
    logic [KHZ_W-1:0]   min_khz = '0;
    logic [KHZ_W-1:0]   max_khz = 25'h1FFFFFF;
    logic [KHZ_W-1:0]   result_khz;
    logic               running, done, pass, fast, slow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk_ref = ~clk_ref;           // 125 MHz
    always #2 test_clks[0] = ~test_clks[0]; // 4 ns period
    always #6 test_clks[1] = ~test_clks[1]; // 12 ns period
    always #10 test_clks[2] = ~test_clks[2]; // 20 ns period

    freq_meter dut_i (
        .clk_ref(clk_ref), .rst_n(rst_n), .start(start), .src_sel(src_sel),
        .test_clks(test_clks), .ref_khz(ref_khz), .settle_cycles(settle_cycles),
        .gate_log2(gate_log2), .min_khz(min_khz), .max_khz(max_khz),
        .result_khz(result_khz), .running(running), .done(done),
        .pass(pass), .fast(fast), .slow(slow)
    );

    function automatic int period_ns(int s);
        return (s == 1) ? 4 : ((s == 2) ? 12 : 20);
    endfunction

    function automatic int nominal_khz(int s, int rk);
        return rk * 8 / period_ns(s);
    endfunction

    function automatic int tol_khz(int n);
        return 2 * ((1000 >> n) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input int s);
        @(negedge clk_ref);
        src_sel = SRC_W'(s);
        start   = 1'b1;
        @(negedge clk_ref);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 4000) begin
            @(negedge clk_ref);
            lat++;
        end
        check(done == 1'b1, "R6", "completion within bound", done, 1);
    endtask

    task automatic measure(input int s, output int lat);
        pulse_start(s);
        wait_done(lat);
    endtask

    task automatic check_grade(input string req);
        bit ef, es, ep;
        ef = result_khz > max_khz;
        es = !ef && (result_khz < min_khz);
        ep = !ef && !es;
        check(fast == ef, req, "fast flag", fast, ef);
        check(slow == es, req, "slow flag", slow, es);
        check(pass == ep, req, "pass flag", pass, ep);
    endtask

    task automatic check_result(input int s, input string req);
        int exp, diff;
        exp  = nominal_khz(s, int'(ref_khz));
        diff = int'(result_khz) - exp;
        if (diff < 0) diff = -diff;
        check(diff <= tol_khz(int'(gate_log2)), req, "result kHz", result_khz, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk_ref);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "R6", "watchdog expired", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int lat0, lat1, lat2, lat;
        logic [KHZ_W-1:0] held;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk_ref);
        // R1 reset state
        check(!running && !done, "R1", "running/done after reset", {running, done}, 0);
        check(!pass && !fast && !slow, "R1", "flags after reset", {pass, fast, slow}, 0);
        check(result_khz == 0, "R1", "result after reset", result_khz, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_ref);

        // baseline: src1, ref 2000, N=4, settle 0, open window (R8, R11, R6)
        measure(1, lat0);
        check_result(1, "R11");
        check(pass == 1'b1, "R8", "open window passes", pass, 1);

        // R10 result held while idle
        held = result_khz;
        repeat (30) @(negedge clk_ref);
        check(done && result_khz == held, "R10", "result held", result_khz, held);

        // R4 settle delay adds exactly its count
        settle_cycles = 8'd10;
        measure(1, lat1);
        check(lat1 - lat0 == 10, "R4", "latency delta for settle 10", lat1 - lat0, 10);
        settle_cycles = 8'd0;

        // R5 gate length: N 4->5 with D=2 adds 2*16 cycles
        gate_log2 = 4'd5;
        measure(1, lat2);
        check(lat2 - lat0 == 32, "R5", "latency delta for N+1", lat2 - lat0, 32);
        gate_log2 = 4'd4;

        // R2 start clears status
        pulse_start(2);
        check(running && !done, "R2", "running after start", {running, done}, 2);
        check(!pass && !fast && !slow, "R2", "flags cleared by start", {pass, fast, slow}, 0);
        wait_done(lat);
        check_result(2, "R11");

        // R9 restart mid-gate
        pulse_start(1);
        repeat (15) @(negedge clk_ref);
        measure(1, lat);
        check(lat == lat0, "R9", "restart latency", lat, lat0);
        check_result(1, "R9");

        // R3 stop with index 0
        pulse_start(3);
        repeat (5) @(negedge clk_ref);
        pulse_start(0);
        check(!running && !done, "R3", "stopped by index 0", {running, done}, 0);
        repeat (120) @(negedge clk_ref);
        check(!done && !running, "R3", "no completion after stop", {running, done}, 0);

        // R7 directed fast and slow on src3 (about 800 kHz)
        max_khz = 25'd500;
        measure(3, lat);
        check(fast == 1'b1, "R7", "fast above max", fast, 1);
        check_grade("R7");
        min_khz = 25'd2000; max_khz = 25'd5000;
        measure(3, lat);
        check(slow == 1'b1, "R7", "slow below min", slow, 1);
        check_grade("R7");

        // random mix
        for (int it = 0; it < 24; it++) begin
            int s, a, b;
            s = 1 + int'($urandom_range(2, 0));
            ref_khz       = KHZ_W'(1000 * (1 + $urandom_range(2, 0)));
            gate_log2     = 4'($urandom_range(6, 2));
            settle_cycles = 8'($urandom_range(20, 0));
            a = int'($urandom_range(7000, 0));
            b = int'($urandom_range(7000, 0));
            min_khz = KHZ_W'((a < b) ? a : b);
            max_khz = KHZ_W'((a < b) ? b : a);
            measure(s, lat);
            check_result(s, "R6");
            check_grade("R7");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule